// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Select

This block holds the counting logic of an integer-N frequency synthesizer. The local-oscillator clock first passes through a fixed divide-by-two stage. A programmable main divider then counts those halved ticks. The reference clock drives a second divider whose ratio is one of four values. Each divider emits a short pulse once per full cycle, and both pulses are handed to an external phase/frequency detector.

A two-bit test code decides what appears on a shared lock/test pin. The choices are the detector's lock flag, the reference pulse, a square wave made from the main pulse, or the raw main pulse. The same code produces enables for the in-phase and quadrature transmit mixers.

Ratios and the test code arrive as parallel inputs. The halved oscillator signal stays internal. A changed ratio is loaded only at terminal count, so every divide cycle runs to completion.

Top module: `synth_div_top`

## Requirements
- R1: With main ratio N (64..511), `mainDivOut` pulses once every 2*N `loClk` cycles, and each pulse is exactly one `loClk` cycle wide.
- R2: A main ratio input below 64 is treated as 64, giving a period of 128 `loClk` cycles.
- R3: `refSel` selects the reference ratio as follows: 2'b00 gives 8, 2'b01 gives 11, 2'b10 gives 22 and 2'b11 gives 44. `refDivOut` pulses once every ratio `refClk` cycles, and each pulse is one `refClk` cycle wide.
- R4: The first divide cycles after reset use a main ratio of 352 and a reference ratio of 22, whatever the inputs are. The first main pulse comes 704 `loClk` cycles after reset release, and the first reference pulse comes 22 `refClk` cycles after release.
- R5: A ratio change takes effect only at the next terminal count. The interval in progress keeps the old ratio, and the interval after it uses the new one.
- R6: With `testSel` = 2'b00, `lockTestOut` follows `lockDetIn`, and both `iMixEn` and `qMixEn` are 1.
- R7: With `testSel` = 2'b01, `lockTestOut` equals `refDivOut`, `iMixEn` = 1 and `qMixEn` = 0.
- R8: With `testSel` = 2'b10, `lockTestOut` is a square wave that toggles on every main pulse, so its period is 4*N `loClk` cycles. In this code `iMixEn` = 0 and `qMixEn` = 1.
- R9: With `testSel` = 2'b11, `lockTestOut` equals `mainDivOut`, and both mixer enables are 0.
- R10: While `rstN` is low, `mainDivOut` and `refDivOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| loClk | input | 1 | Local-oscillator input clock |
| refClk | input | 1 | Reference input clock |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| mainRatio | input | 9 | Requested main divide ratio |
| refSel | input | 2 | Reference ratio code |
| testSel | input | 2 | Test code for the lock pin and the mixer gating |
| lockDetIn | input | 1 | Lock flag from the phase detector |
| mainDivOut | output | 1 | Main divider pulse to the phase detector |
| refDivOut | output | 1 | Reference divider pulse to the phase detector |
| lockTestOut | output | 1 | Shared lock/test pin |
| iMixEn | output | 1 | In-phase transmit mixer enable |
| qMixEn | output | 1 | Quadrature transmit mixer enable |

## Verification
The bench builds the block with its default parameters: a 9-bit main ratio, a floor of 64, a main reset ratio of 352, and the reference ratio set 8/11/22/44. These values keep even the longest interval at 1022 oscillator cycles. That short length lets the bench run the following in a few thousand cycles:
- the full main range, from the clamp boundary at 63/64 up to the maximum of 511;
- the four reference codes;
- the reset-default intervals;
- the deferred ratio loads;
- every test code.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MAIN_W = 9;
  localparam int REF_W  = 6;

  typedef enum logic [1:0] {
    LK_DETECT = 2'b00,
    LK_REF    = 2'b01,
    LK_MAINSQ = 2'b10,
    LK_MAIN   = 2'b11
  } lock_src_e;

  typedef struct packed {
    logic              loTick;
    logic [MAIN_W-1:0] mainNext;
    logic [REF_W-1:0]  refNext;
    logic              iMixOn;
    logic              qMixOn;
    lock_src_e         lockSrc;
  } div_strobe_t;
endpackage

// File: rtl/synth_div_counter.sv
module synth_div_counter #(
  parameter int W           = 9,
  parameter int RESET_RATIO = 352,
  parameter int MIN_RATIO   = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] nextRatio,
  output logic         pulse,
  output logic [W-1:0] activeRatio
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [W-1:0] RESET_LOAD = W'(RESET_RATIO - 1);
  localparam logic [W-1:0] RESET_VAL  = W'(RESET_RATIO);
  localparam logic [W-1:0] MIN_VAL    = W'(MIN_RATIO);

  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain      <= RESET_LOAD;
      activeRatio <= RESET_VAL;
      pulse       <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (remain == '0) begin
          pulse       <= 1'b1;
          remain      <= nextRatio - 1'b1;
          activeRatio <= nextRatio;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  // R1 / R3: every divider pulse lasts a single clock
  a_r1_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);

  // R5: the working ratio moves only together with a terminal-count pulse
  a_r5_load_at_terminal: assert property (@(posedge clk) disable iff (!rstN)
    (activeRatio != $past(activeRatio)) |-> pulse);

  // R2: no ratio below the floor is ever in use
  a_r2_ratio_floor: assert property (@(posedge clk) disable iff (!rstN)
    activeRatio >= MIN_VAL);

  // R1: the countdown stays inside the current cycle
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    remain < activeRatio);
endmodule

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
  import synth_div_pkg::*;
#(
  parameter int MAIN_MIN  = 64,
  parameter int REF_RAT_0 = 8,
  parameter int REF_RAT_1 = 11,
  parameter int REF_RAT_2 = 22,
  parameter int REF_RAT_3 = 44
) (
  input  logic              loClk,
  input  logic              rstN,
  input  logic [MAIN_W-1:0] mainRatio,
  input  logic [1:0]        refSel,
  input  logic [1:0]        testSel,
  output div_strobe_t       strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [MAIN_W-1:0] FLOOR = MAIN_W'(MAIN_MIN);

  logic halfPhase;

  always_ff @(posedge loClk or negedge rstN) begin
    if (!rstN) halfPhase <= 1'b0;
    else       halfPhase <= ~halfPhase;
  end

  always_comb begin
    strobe.loTick   = halfPhase;
    strobe.mainNext = (mainRatio < FLOOR) ? FLOOR : mainRatio;
    unique case (refSel)
      2'b00:   strobe.refNext = REF_W'(REF_RAT_0);
      2'b01:   strobe.refNext = REF_W'(REF_RAT_1);
      2'b10:   strobe.refNext = REF_W'(REF_RAT_2);
      default: strobe.refNext = REF_W'(REF_RAT_3);
    endcase
    strobe.iMixOn  = ~testSel[1];
    strobe.qMixOn  = ~testSel[0];
    strobe.lockSrc = lock_src_e'(testSel);
  end

  // R1: the halving stage ticks on every other oscillator cycle
  a_r1_half_rate: assert property (@(posedge loClk) disable iff (!rstN)
    strobe.loTick |=> !strobe.loTick);
  a_r1_half_rate_b: assert property (@(posedge loClk) disable iff (!rstN)
    !strobe.loTick |=> strobe.loTick);
endmodule

// File: rtl/synth_div_path.sv
module synth_div_path
  import synth_div_pkg::*;
#(
  parameter int MAIN_MIN     = 64,
  parameter int MAIN_DEFAULT = 352,
  parameter int REF_DEFAULT  = 22,
  parameter int REF_MIN      = 8
) (
  input  logic        loClk,
  input  logic        refClk,
  input  logic        rstN,
  input  div_strobe_t strobe,
  input  logic        lockDetIn,
  output logic        mainDivOut,
  output logic        refDivOut,
  output logic        lockTestOut,
  output logic        iMixEn,
  output logic        qMixEn
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [MAIN_W-1:0] mainActive;
  logic [REF_W-1:0]  refActive;
  logic              mainSquare;

  synth_div_counter #(.W(MAIN_W), .RESET_RATIO(MAIN_DEFAULT), .MIN_RATIO(MAIN_MIN)) u_main (
    .clk(loClk), .rstN(rstN), .tick(strobe.loTick), .nextRatio(strobe.mainNext),
    .pulse(mainDivOut), .activeRatio(mainActive));

  synth_div_counter #(.W(REF_W), .RESET_RATIO(REF_DEFAULT), .MIN_RATIO(REF_MIN)) u_ref (
    .clk(refClk), .rstN(rstN), .tick(1'b1), .nextRatio(strobe.refNext),
    .pulse(refDivOut), .activeRatio(refActive));

  always_ff @(posedge loClk or negedge rstN) begin
    if (!rstN)           mainSquare <= 1'b0;
    else if (mainDivOut) mainSquare <= ~mainSquare;
  end

  always_comb begin
    unique case (strobe.lockSrc)
      LK_DETECT: lockTestOut = lockDetIn;
      LK_REF:    lockTestOut = refDivOut;
      LK_MAINSQ: lockTestOut = mainSquare;
      default:   lockTestOut = mainDivOut;
    endcase
    iMixEn = strobe.iMixOn;
    qMixEn = strobe.qMixOn;
  end

  // R8: the square wave changes only right after a main pulse
  a_r8_square_follows: assert property (@(posedge loClk) disable iff (!rstN)
    !$stable(mainSquare) |-> $past(mainDivOut));
endmodule

// File: rtl/synth_div_top.sv
module synth_div_top
  import synth_div_pkg::*;
#(
  parameter int MAIN_MIN     = 64,
  parameter int MAIN_DEFAULT = 352,
  parameter int REF_RAT_0    = 8,
  parameter int REF_RAT_1    = 11,
  parameter int REF_RAT_2    = 22,
  parameter int REF_RAT_3    = 44
) (
  input  logic       loClk,
  input  logic       refClk,
  input  logic       rstN,
  input  logic [8:0] mainRatio,
  input  logic [1:0] refSel,
  input  logic [1:0] testSel,
  input  logic       lockDetIn,
  output logic       mainDivOut,
  output logic       refDivOut,
  output logic       lockTestOut,
  output logic       iMixEn,
  output logic       qMixEn
);
  timeunit 1ns;
  timeprecision 1ps;

  div_strobe_t strobe;

  synth_div_ctrl #(.MAIN_MIN(MAIN_MIN), .REF_RAT_0(REF_RAT_0), .REF_RAT_1(REF_RAT_1),
                   .REF_RAT_2(REF_RAT_2), .REF_RAT_3(REF_RAT_3)) u_ctrl (
    .loClk(loClk), .rstN(rstN), .mainRatio(mainRatio), .refSel(refSel),
    .testSel(testSel), .strobe(strobe));

  synth_div_path #(.MAIN_MIN(MAIN_MIN), .MAIN_DEFAULT(MAIN_DEFAULT),
                   .REF_DEFAULT(REF_RAT_2), .REF_MIN(REF_RAT_0)) u_path (
    .loClk(loClk), .refClk(refClk), .rstN(rstN), .strobe(strobe), .lockDetIn(lockDetIn),
    .mainDivOut(mainDivOut), .refDivOut(refDivOut), .lockTestOut(lockTestOut),
    .iMixEn(iMixEn), .qMixEn(qMixEn));

  // R7 / R8: the two mixed test codes gate exactly one mixer
  a_r7_one_mixer: assert property (@(posedge loClk) disable iff (!rstN)
    (testSel == 2'b01 || testSel == 2'b10) |-> $countones({iMixEn, qMixEn}) == 1);

  // R9: the main-pulse test code gates both mixers
  a_r9_both_off: assert property (@(posedge loClk) disable iff (!rstN)
    (testSel == 2'b11) |-> (!iMixEn && !qMixEn));

  // R6: normal operation leaves both mixers running
  a_r6_both_on: assert property (@(posedge loClk) disable iff (!rstN)
    (testSel == 2'b00) |-> (iMixEn && qMixEn));
endmodule

// File: tb/synth_div_top_test.sv
module synth_div_top_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       loClk = 1'b0;
  logic       refClk = 1'b0;
  logic       rstN;
  logic [8:0] mainRatio;
  logic [1:0] refSel;
  logic [1:0] testSel;
  logic       lockDetIn;
  logic       mainDivOut, refDivOut, lockTestOut, iMixEn, qMixEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 loClk = ~loClk;
  always #7 refClk = ~refClk;

  synth_div_top uut (
    .loClk(loClk), .refClk(refClk), .rstN(rstN), .mainRatio(mainRatio), .refSel(refSel),
    .testSel(testSel), .lockDetIn(lockDetIn), .mainDivOut(mainDivOut), .refDivOut(refDivOut),
    .lockTestOut(lockTestOut), .iMixEn(iMixEn), .qMixEn(qMixEn));

  localparam int NVEC = 6;
  localparam int VEC_MAIN [NVEC] = '{64, 352, 511, 100, 40, 63};
  localparam int VEC_SEL  [NVEC] = '{0, 1, 2, 3, 0, 1};
  localparam int VEC_MEXP [NVEC] = '{128, 704, 1022, 200, 128, 128};
  localparam int VEC_REXP [NVEC] = '{8, 11, 22, 44, 8, 11};

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic waitMain();
    do @(negedge loClk); while (!mainDivOut);
  endtask

  task automatic countMain(output int n);
    n = 0;
    do begin @(negedge loClk); n++; end while (!mainDivOut);
  endtask

  task automatic waitRef();
    do @(negedge refClk); while (!refDivOut);
  endtask

  task automatic countRef(output int n);
    n = 0;
    do begin @(negedge refClk); n++; end while (!refDivOut);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, nRef, mism, highs;
    rstN = 1'b0; mainRatio = 9'd100; refSel = 2'b00; testSel = 2'b00; lockDetIn = 1'b0;
    repeat (5) @(negedge loClk);
    // R10: divider outputs quiet in reset
    checkEq("R10 mainDivOut in reset", int'(mainDivOut), 0);
    checkEq("R10 refDivOut in reset", int'(refDivOut), 0);

    // R4: first intervals use the reset defaults
    @(negedge loClk);
    rstN = 1'b1;
    fork
      begin n = 0; do begin @(negedge loClk); n++; end while (!mainDivOut); end
      begin nRef = 0; do begin @(negedge refClk); nRef++; end while (!refDivOut); end
    join
    checkRange("R4 first main pulse", n, 700, 708);
    checkRange("R4 first ref pulse", nRef, 20, 24);
    countMain(n);
    checkEq("R1 main period N=100", n, 200);

    // R1 R2 R3: table walk
    for (int i = 0; i < NVEC; i++) begin
      mainRatio = 9'(VEC_MAIN[i]);
      refSel    = 2'(VEC_SEL[i]);
      waitMain();
      countMain(n);
      checkEq((VEC_MAIN[i] < 64) ? "R2 clamped main period" : "R1 main period", n, VEC_MEXP[i]);
      waitRef();
      countRef(nRef);
      checkEq("R3 ref period", nRef, VEC_REXP[i]);
    end

    // R5: change in mid-cycle keeps the running interval
    waitMain();
    mainRatio = 9'd200;
    countMain(n);
    checkEq("R5 main interval in progress", n, 128);
    countMain(n);
    checkEq("R5 main next interval", n, 400);
    waitRef();
    refSel = 2'b11;
    countRef(nRef);
    checkEq("R5 ref interval in progress", nRef, 11);
    countRef(nRef);
    checkEq("R5 ref next interval", nRef, 44);

    // R6
    testSel = 2'b00; lockDetIn = 1'b1;
    @(negedge loClk);
    checkEq("R6 lock pin high", int'(lockTestOut), 1);
    checkEq("R6 mixer enables", int'({iMixEn, qMixEn}), 3);
    lockDetIn = 1'b0;
    @(negedge loClk);
    checkEq("R6 lock pin low", int'(lockTestOut), 0);

    // R7
    testSel = 2'b01; lockDetIn = 1'b1;
    mism = 0; highs = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge refClk);
      if (lockTestOut != refDivOut) mism++;
      if (lockTestOut) highs++;
    end
    checkEq("R7 lock pin vs ref pulse", mism, 0);
    checkRange("R7 ref pulses seen", highs, 1, 200);
    checkEq("R7 mixer enables", int'({iMixEn, qMixEn}), 2);

    // R9
    testSel = 2'b11;
    mism = 0; highs = 0;
    for (int k = 0; k < 900; k++) begin
      @(negedge loClk);
      if (lockTestOut != mainDivOut) mism++;
      if (lockTestOut) highs++;
    end
    checkEq("R9 lock pin vs main pulse", mism, 0);
    checkRange("R9 main pulses seen", highs, 1, 900);
    checkEq("R9 mixer enables", int'({iMixEn, qMixEn}), 0);

    // R8: square wave period 4*N = 800
    testSel = 2'b10;
    do @(negedge loClk); while (lockTestOut);
    do @(negedge loClk); while (!lockTestOut);
    n = 0;
    do begin @(negedge loClk); n++; end while (lockTestOut);
    do begin @(negedge loClk); n++; end while (!lockTestOut);
    checkEq("R8 square period", n, 800);
    checkEq("R8 mixer enables", int'({iMixEn, qMixEn}), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule